// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter for general use. It is clocked from an instruction-rate tick, which is the system clock divided by four, after that tick passes through a selectable prescaler. The count is compared with a writable period value. When the count equals the period, the next increment returns the counter to zero and raises a one-cycle match pulse. That pulse leaves the block unscaled, so that a PWM time base or a serial shift-clock generator can use it.

The same match pulse also steps a 4-bit postscaler. Every (N+1)th match sets a sticky interrupt flag. The interrupt line is driven only while both the flag and an interrupt-enable bit are set. Software reaches the count, period, control, flag and enable registers through a simple single-cycle register port. Reads are combinational.

Register addresses: 0 = count, 1 = period, 2 = control, 3 = flag (bit 0), 4 = interrupt enable (bit 0). Control fields: bits 6:3 = postscale select N, bit 2 = run enable, bits 1:0 = prescale select, bit 7 reads as 0.

Top module: `period_timer`

## Requirements
- R1: After reset, count reads 0x00, period reads 0xFF, control reads 0x00, and both the flag and the interrupt enable read 0.
- R2: Control bits 6:0 read back as written. Bit 7 always reads 0.
- R3: While the timer runs, consecutive match pulses are (P+1)*4*D system clocks apart. P is the period. D is the prescale ratio: select 00 gives D = 1, 01 gives D = 4, and 10 or 11 give D = 16.
- R4: The match pulse lasts exactly one cycle, and the count reads 0 while it is high.
- R5: With postscale select N in control bits 6:3, the flag is set on the (N+1)th match after the postscaler was last cleared. It is set one cycle after that match pulse.
- R6: The flag is sticky. Writing 0 to flag bit 0 clears it. Writing 1 leaves it unchanged.
- R7: irq_o is 1 exactly when the flag and the enable bit are both 1.
- R8: While run enable (control bit 2) is 0, the count holds its value.
- R9: A write to the count register loads the count. A write to count or control restarts the clock divider, the prescaler and the postscaler from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| match_o | output | 1 | Unscaled period-match pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a postscaler ratio at its extreme together with the slowest count rate. At a period of 0xFF and a divide-by-16 prescale, the match interval is 16384 clocks. The bench therefore measures intervals between successive match pulses rather than absolute times, and it restarts the dividers with a control write before each run so that every run starts from a known phase. Flag cadence is checked on a short period, counting matches up to the first flag rise for postscale values 0, 7 and 15.

// File: rtl/period_timer_pkg.sv
package period_timer_pkg;
  typedef enum logic [2:0] {
    ADDR_COUNT  = 3'd0,
    ADDR_PERIOD = 3'd1,
    ADDR_CTRL   = 3'd2,
    ADDR_FLAG   = 3'd3,
    ADDR_IEN    = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic [3:0] post_sel;
    logic       run;
    logic [1:0] pre_sel;
  } ctrl_t;
endpackage

// File: rtl/tm_prescaler.sv
module tm_prescaler #(
  parameter int BASE_DIV = 4,
  parameter int MAX_DIV  = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  localparam int QW = $clog2(BASE_DIV);
  localparam int PW = $clog2(MAX_DIV);

  logic [QW-1:0] base_q;
  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_last;
  logic          base_wrap;

  always_comb begin
    case (sel_i)
      2'b00:   pre_last = '0;
      2'b01:   pre_last = PW'(3);
      default: pre_last = PW'(MAX_DIV - 1);
    endcase
  end

  assign base_wrap = (base_q == QW'(BASE_DIV - 1));
  assign tick_o    = en_i && base_wrap && (pre_q == pre_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      pre_q  <= '0;
    end else if (clr_i) begin
      base_q <= '0;
      pre_q  <= '0;
    end else if (en_i) begin
      if (base_wrap) begin
        base_q <= '0;
        pre_q  <= (pre_q == pre_last) ? '0 : pre_q + 1'b1;
      end else begin
        base_q <= base_q + 1'b1;
      end
    end
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tm_counter.sv
module tm_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] period_i,
  output logic [WIDTH-1:0] count_o,
  output logic             match_o
);
  logic [WIDTH-1:0] count_q;
  logic             match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      match_q <= 1'b0;
    end else if (wr_i) begin
      count_q <= wdata_i;
      match_q <= 1'b0;
    end else if (tick_i && count_q == period_i) begin
      count_q <= '0;
      match_q <= 1'b1;
    end else begin
      if (tick_i) count_q <= count_q + 1'b1;
      match_q <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign match_o = match_q;

  // R4
  match_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_q |-> count_q == '0);
  // R4
  match_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_q |=> !match_q);
endmodule

// File: rtl/tm_postscaler.sv
module tm_postscaler #(
  parameter int PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          match_i,
  input  logic [PW-1:0] sel_i,
  input  logic          flag_wr_i,
  input  logic          flag_wbit_i,
  output logic          flag_o
);
  logic [PW-1:0] post_q;
  logic          flag_q;
  logic          hit;

  assign hit = match_i && !clr_i && (post_q == sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      post_q <= '0;
    end else if (clr_i) begin
      post_q <= '0;
    end else if (match_i) begin
      post_q <= hit ? '0 : post_q + 1'b1;
    end
  end

  // set wins over a same-cycle software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       flag_q <= 1'b0;
    else if (hit)                      flag_q <= 1'b1;
    else if (flag_wr_i && !flag_wbit_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R5
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(match_i));
endmodule

// File: rtl/period_timer.sv
module period_timer
  import period_timer_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int BASE_DIV = 4,
  parameter int MAX_DIV  = 16,
  parameter int POST_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             match_o,
  output logic             irq_o
);
  ctrl_t            ctrl_q;
  logic [WIDTH-1:0] period_q;
  logic             ien_q;
  logic [WIDTH-1:0] count;
  logic             flag;
  logic             tick;
  logic             wr_count, wr_ctrl, wr_flag, div_clr;

  assign wr_count = we_i && addr_i == ADDR_COUNT;
  assign wr_ctrl  = we_i && addr_i == ADDR_CTRL;
  assign wr_flag  = we_i && addr_i == ADDR_FLAG;
  assign div_clr  = wr_count || wr_ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      period_q <= '1;
      ien_q    <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_PERIOD: period_q <= wdata_i;
        ADDR_CTRL:   ctrl_q   <= ctrl_t'(wdata_i[6:0]);
        ADDR_IEN:    ien_q    <= wdata_i[0];
        default: ;
      endcase
    end
  end

  tm_prescaler #(.BASE_DIV(BASE_DIV), .MAX_DIV(MAX_DIV)) i_pre (
    .clk_i, .rst_ni,
    .clr_i  (div_clr),
    .en_i   (ctrl_q.run),
    .sel_i  (ctrl_q.pre_sel),
    .tick_o (tick)
  );

  tm_counter #(.WIDTH(WIDTH)) i_cnt (
    .clk_i, .rst_ni,
    .tick_i   (tick),
    .wr_i     (wr_count),
    .wdata_i  (wdata_i),
    .period_i (period_q),
    .count_o  (count),
    .match_o  (match_o)
  );

  tm_postscaler #(.PW(POST_W)) i_post (
    .clk_i, .rst_ni,
    .clr_i       (div_clr),
    .match_i     (match_o),
    .sel_i       (ctrl_q.post_sel),
    .flag_wr_i   (wr_flag),
    .flag_wbit_i (wdata_i[0]),
    .flag_o      (flag)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_COUNT:  rdata_o = count;
      ADDR_PERIOD: rdata_o = period_q;
      ADDR_CTRL:   rdata_o = WIDTH'({1'b0, ctrl_q});
      ADDR_FLAG:   rdata_o = WIDTH'(flag);
      ADDR_IEN:    rdata_o = WIDTH'(ien_q);
      default:     rdata_o = '0;
    endcase
  end

  assign irq_o = flag && ien_q;

  // R8
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && !wr_count) |=> $stable(count));
  // R2
  ctrl_top_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_CTRL) |-> !rdata_o[7]);
endmodule

// File: tb/test_period_timer.sv
module test_period_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       match_o, irq_o;

  int tests = 0, fails = 0;
  int cyc = 0;
  int exp_q[$];
  bit skip = 1'b0;
  int last_match = 0;

  always #5 clk_i = ~clk_i;

  period_timer i_period_timer (.*);

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk_i);
    addr_i = a;
    #1 v = int'(rdata_o);
  endtask

  // monitor: match interval scoreboard and one-cycle pulse check
  bit prev_match = 1'b0;
  always @(negedge clk_i) begin
    cyc++;
    if (match_o && prev_match) chk("R4 pulse width", 2, 1);
    if (match_o && !prev_match) begin
      if (skip) skip = 1'b0;
      else if (exp_q.size() > 0) chk("R3 interval", cyc - last_match, exp_q.pop_front());
      last_match = cyc;
    end
    prev_match = match_o;
  end

  task automatic run_interval(int p, int ps, int n);
    int d;
    d = (ps == 0) ? 1 : (ps == 1) ? 4 : 16;
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'(p));
    skip = 1'b1;
    for (int i = 0; i < n; i++) exp_q.push_back((p + 1) * 4 * d);
    wr(3'd2, {5'b00001, 2'(ps)});
    while (exp_q.size() > 0) @(negedge clk_i);
  endtask

  task automatic run_cadence(int n);
    int m, v;
    wr(3'd2, 8'h00);
    wr(3'd1, 8'd3);
    wr(3'd0, 8'd0);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h01);
    wr(3'd2, {1'b0, 4'(n), 3'b100});
    m = 0;
    while (!irq_o) begin
      @(negedge clk_i);
      if (match_o) m++;
    end
    chk("R5 matches to flag", m, n + 1);
    rd(3'd3, v);
    chk("R5 flag read", v, 1);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    rd(3'd0, v); chk("R1 count", v, 0);
    rd(3'd1, v); chk("R1 period", v, 255);
    rd(3'd2, v); chk("R1 control", v, 0);
    rd(3'd3, v); chk("R1 flag", v, 0);
    rd(3'd4, v); chk("R1 enable", v, 0);
    chk("R7 irq at reset", int'(irq_o), 0);

    wr(3'd2, 8'hFB);
    rd(3'd2, v); chk("R2 control readback", v, 8'h7B);
    wr(3'd2, 8'h00);

    // R9 load, R8 hold while stopped
    wr(3'd0, 8'd5);
    rd(3'd0, v); chk("R9 count load", v, 5);
    repeat (100) @(negedge clk_i);
    rd(3'd0, v); chk("R8 hold while off", v, 5);

    // R9 first increment arrives 4 clocks after control write
    wr(3'd0, 8'd0);
    wr(3'd1, 8'd200);
    @(negedge clk_i); addr_i = 3'd2; wdata_i = 8'h04; we_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0; addr_i = 3'd0;
    repeat (3) @(negedge clk_i);
    #1 chk("R9 before first tick", int'(rdata_o), 0);
    @(negedge clk_i);
    #1 chk("R9 first tick", int'(rdata_o), 1);

    run_interval(0, 0, 3); run_interval(0, 1, 3); run_interval(0, 2, 3);
    run_interval(1, 0, 3); run_interval(1, 1, 3); run_interval(1, 2, 3);
    run_interval(1, 3, 2);
    run_interval(255, 0, 2); run_interval(255, 1, 2); run_interval(255, 2, 2);

    run_cadence(0);
    run_cadence(7);
    run_cadence(15);

    // R6 sticky flag, R7 gating
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h01);
    rd(3'd3, v); chk("R6 write 1 keeps flag", v, 1);
    wr(3'd4, 8'h00);
    chk("R7 irq masked", int'(irq_o), 0);
    wr(3'd4, 8'h01);
    chk("R7 irq enabled", int'(irq_o), 1);
    wr(3'd3, 8'h00);
    rd(3'd3, v); chk("R6 write 0 clears", v, 0);
    chk("R7 irq after clear", int'(irq_o), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1900000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule